// File: doc/BRIEF.md
# Instruction Cycle Cost Calculator

This block works out how many clock cycles one instruction of a small 8-bit processor occupies. It then times that many cycles and raises a one-cycle completion pulse at the end. The sequencer presents four things together with a one-cycle start strobe:

- the instruction class: plain read/ALU, read-modify-write, branch, or implied;
- the addressing mode;
- the page-crossing flag from address generation;
- for branches, the taken and target-page-change flags.

The block latches the cost onto its output. It loads an internal down-counter with that cost and pulses the completion output as the count passes through one.

The cost does not come from a static table. It depends on two dynamic conditions, whether indexing crossed a page and whether a branch was taken. A store in an indexed mode always pays the crossed cost, and a read-modify-write always does. A new start while a count is running abandons the old instruction and times the new one. Opcode decoding and execution live elsewhere.

Top module: `icc_cycle_cost`

## Requirements
- R1: After reset `cost_o` is 0 and `done_o` is low, and they stay so until the first start.
- R2: Class read (`class_i`=0) costs 2 in modes implied (0), accumulator (1) and immediate (2), 3 in zero page (3), 4 in zero-page indexed (4) and absolute (5), and 6 in pre-indexed indirect (7); unused mode codes 9 to 15 cost 2 in every class.
- R3: Class read costs 4 in absolute indexed (6), or 5 when `page_cross_i` is high. It costs 5 in post-indexed indirect (8), or 6 when `page_cross_i` is high.
- R4: With `store_i` high, class read in modes 6 and 8 always takes the crossed cost (5 and 6). In every other mode `store_i` leaves the cost unchanged.
- R5: Class read-modify-write (`class_i`=1) costs 2 in modes 0, 1 and 2, 5 in mode 3, 6 in modes 4 and 5, 7 in mode 6, and 8 in modes 7 and 8, whatever `page_cross_i` and `store_i` are.
- R6: Class branch (`class_i`=2) costs 2 when `br_taken_i` is low, whatever `br_page_i` is. It costs 3 when taken and 4 when taken with `br_page_i` high.
- R7: Class implied (`class_i`=3) costs 2 for every mode and flag value.
- R8: A start sampled at a clock edge places the cost on `cost_o` at that edge. `cost_o` holds until the next start.
- R9: For a start sampled at edge E with cost N, `done_o` is high for exactly one cycle, the cycle after edge E+N-1, and low in the cycles between.
- R10: A start during a running count restarts timing from the new cost. The abandoned instruction produces no completion pulse.
- R11: With no start, `done_o` stays low once the pulse of the last instruction is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe: the other inputs describe a new instruction |
| class_i | input | 2 | Instruction class: 0 read, 1 read-modify-write, 2 branch, 3 implied |
| mode_i | input | 4 | Addressing mode code, 0 to 8 as listed in the requirements |
| page_cross_i | input | 1 | Indexed address crossed a page boundary |
| store_i | input | 1 | Read-class instruction is a store |
| br_taken_i | input | 1 | Branch condition met |
| br_page_i | input | 1 | Taken branch target lies on another page |
| cost_o | output | CNT_W | Cycle cost of the last started instruction |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default `CNT_W` of 4. The counter then just holds the largest cost of 8, so the full-scale cost exercises the top bit of the counter. With that width, an exhaustive sweep over every class, every mode code including the unused ones, and all sixteen flag combinations becomes a few thousand cycles long. Each of those instructions has its cost and pulse timing checked. Random back-to-back restarts at random points inside a count then probe the reload path against the abandoned pulse.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int COST_W = 4;

  localparam logic [1:0] CLS_READ    = 2'd0;
  localparam logic [1:0] CLS_RMW     = 2'd1;
  localparam logic [1:0] CLS_BRANCH  = 2'd2;
  localparam logic [1:0] CLS_IMPLIED = 2'd3;

  localparam logic [3:0] AM_IMPLIED  = 4'd0;
  localparam logic [3:0] AM_ACCUM    = 4'd1;
  localparam logic [3:0] AM_IMMED    = 4'd2;
  localparam logic [3:0] AM_ZP       = 4'd3;
  localparam logic [3:0] AM_ZP_IDX   = 4'd4;
  localparam logic [3:0] AM_ABS      = 4'd5;
  localparam logic [3:0] AM_ABS_IDX  = 4'd6;
  localparam logic [3:0] AM_IND_PRE  = 4'd7;
  localparam logic [3:0] AM_IND_POST = 4'd8;

  localparam logic [COST_W-1:0] COST_MIN = 4'd2;

  typedef struct packed {
    logic page_cross;
    logic store;
    logic taken;
    logic tgt_page;
  } icc_flags_t;

  // Cost of the memory access pattern of a read-class instruction.
  function automatic logic [COST_W-1:0] read_cost(input logic [3:0] mode,
                                                 input logic crossed);
    logic [COST_W-1:0] extra;
    extra = {{(COST_W-1){1'b0}}, crossed};
    case (mode)
      AM_ZP:       read_cost = 4'd3;
      AM_ZP_IDX,
      AM_ABS:      read_cost = 4'd4;
      AM_ABS_IDX:  read_cost = 4'd4 + extra;
      AM_IND_PRE:  read_cost = 4'd6;
      AM_IND_POST: read_cost = 4'd5 + extra;
      default:     read_cost = COST_MIN;
    endcase
  endfunction

  // Read-modify-write: register-only modes stay at the minimum, memory
  // modes pay the crossed read cost plus a modify and a write-back cycle.
  function automatic logic [COST_W-1:0] rmw_cost(input logic [3:0] mode);
    case (mode)
      AM_ZP, AM_ZP_IDX, AM_ABS, AM_ABS_IDX, AM_IND_PRE, AM_IND_POST:
        rmw_cost = read_cost(mode, 1'b1) + 4'd2;
      default:
        rmw_cost = COST_MIN;
    endcase
  endfunction

  function automatic logic [COST_W-1:0] branch_cost(input logic [1:0] extra);
    branch_cost = COST_MIN + {{(COST_W-2){1'b0}}, extra};
  endfunction

endpackage

// File: rtl/icc_flag_qualify.sv
module icc_flag_qualify
  import icc_pkg::*;
(
  input  icc_flags_t flags_i,
  output logic       eff_cross_o,
  output logic [1:0] br_extra_o
);

  // Stores cannot know the page in time, so they always pay the fix-up cycle.
  assign eff_cross_o = flags_i.page_cross | flags_i.store;

  // Taken adds one; a taken branch to another page adds one more.
  always_comb begin
    br_extra_o = 2'd0;
    if (flags_i.taken) begin
      br_extra_o = flags_i.tgt_page ? 2'd2 : 2'd1;
    end
  end

endmodule

// File: rtl/icc_cost_select.sv
module icc_cost_select
  import icc_pkg::*;
(
  input  logic [1:0]        class_i,
  input  logic [3:0]        mode_i,
  input  logic              eff_cross_i,
  input  logic [1:0]        br_extra_i,
  output logic [COST_W-1:0] cost_o
);

  logic [COST_W-1:0] read_path;
  logic [COST_W-1:0] rmw_path;
  logic [COST_W-1:0] branch_path;

  assign read_path   = read_cost(mode_i, eff_cross_i);
  assign rmw_path    = rmw_cost(mode_i);
  assign branch_path = branch_cost(br_extra_i);

  always_comb begin
    case (class_i)
      CLS_READ:   cost_o = read_path;
      CLS_RMW:    cost_o = rmw_path;
      CLS_BRANCH: cost_o = branch_path;
      default:    cost_o = COST_MIN;
    endcase
  end

endmodule

// File: rtl/icc_countdown.sv
module icc_countdown #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] remain_q;
  logic             running;

  assign running = (remain_q != ZERO);
  assign done_o  = (remain_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= ZERO;
    end else if (load_i) begin
      remain_q <= load_val_i;
    end else if (running) begin
      remain_q <= remain_q - ONE;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> remain_q == $past(load_val_i)); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && remain_q > ONE) |=> remain_q == $past(remain_q) - ONE); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !running) |=> (!running && !done_o)); // R11

endmodule

// File: rtl/icc_cycle_cost.sv
module icc_cycle_cost
  import icc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       class_i,
  input  logic [3:0]       mode_i,
  input  logic             page_cross_i,
  input  logic             store_i,
  input  logic             br_taken_i,
  input  logic             br_page_i,
  output logic [CNT_W-1:0] cost_o,
  output logic             done_o
);

  icc_flags_t        flags;
  logic              eff_cross;
  logic [1:0]        br_extra;
  logic [COST_W-1:0] cost_raw;
  logic [CNT_W-1:0]  cost_ext;
  logic [CNT_W-1:0]  cost_q;

  assign flags.page_cross = page_cross_i;
  assign flags.store      = store_i;
  assign flags.taken      = br_taken_i;
  assign flags.tgt_page   = br_page_i;

  icc_flag_qualify u_qualify (
    .flags_i     (flags),
    .eff_cross_o (eff_cross),
    .br_extra_o  (br_extra)
  );

  icc_cost_select u_select (
    .class_i     (class_i),
    .mode_i      (mode_i),
    .eff_cross_i (eff_cross),
    .br_extra_i  (br_extra),
    .cost_o      (cost_raw)
  );

  generate
    if (CNT_W == COST_W) begin : g_same_w
      assign cost_ext = cost_raw;
    end else begin : g_pad_w
      assign cost_ext = {{(CNT_W-COST_W){1'b0}}, cost_raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q <= '0;
    end else if (start_i) begin
      cost_q <= cost_ext;
    end
  end

  icc_countdown #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .load_val_i (cost_ext),
    .done_o     (done_o)
  );

  assign cost_o = cost_q;

  AST_COST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(cost_o)); // R8

  AST_COST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cost_o >= 2 && cost_o <= 8)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && class_i == CLS_BRANCH && !br_taken_i) |=> cost_o == 2); // R6

  AST_RMW_ABS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && class_i == CLS_RMW && mode_i == AM_ABS_IDX) |=> cost_o == 7); // R5

  AST_STORE_CROSSED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && class_i == CLS_READ && store_i && mode_i == AM_ABS_IDX)
      |=> cost_o == 5); // R4

  AST_IMPLIED_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && class_i == CLS_IMPLIED) |=> cost_o == 2); // R7

endmodule

// File: tb/test_icc_cycle_cost.sv
module test_icc_cycle_cost;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       class_i = '0;
  logic [3:0]       mode_i = '0;
  logic             page_cross_i = 1'b0;
  logic             store_i = 1'b0;
  logic             br_taken_i = 1'b0;
  logic             br_page_i = 1'b0;
  logic [CNT_W-1:0] cost_o;
  logic             done_o;

  int n_checks = 0;
  int n_fail = 0;

  icc_cycle_cost #(.CNT_W(CNT_W)) i_icc_cycle_cost (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .class_i      (class_i),
    .mode_i       (mode_i),
    .page_cross_i (page_cross_i),
    .store_i      (store_i),
    .br_taken_i   (br_taken_i),
    .br_page_i    (br_page_i),
    .cost_o       (cost_o),
    .done_o       (done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected cost, written class first from the requirements.
  function automatic int ref_cost(int cls, int mode, bit pc, bit st, bit tk, bit pg);
    int base;
    bit crossed;
    if (cls == 3) return 2;                                  // R7
    if (cls == 2) return 2 + (tk ? 1 : 0) + ((tk && pg) ? 1 : 0); // R6
    if (mode <= 2 || mode > 8) return 2;
    crossed = (cls == 1) ? 1'b1 : (pc || st);
    case (mode)
      3:       base = 3;
      6:       base = crossed ? 5 : 4;
      7:       base = 6;
      8:       base = crossed ? 6 : 5;
      default: base = 4;
    endcase
    return (cls == 1) ? base + 2 : base;                     // R5
  endfunction

  function automatic string tag_for(int cls, int mode, bit st);
    if (cls == 1) return "R5";
    if (cls == 2) return "R6";
    if (cls == 3) return "R7";
    if (mode == 6 || mode == 8) return st ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int cls, int mode, bit pc, bit st, bit tk, bit pg);
    start_i      = 1'b1;
    class_i      = 2'(cls);
    mode_i       = 4'(mode);
    page_cross_i = pc;
    store_i      = st;
    br_taken_i   = tk;
    br_page_i    = pg;
  endtask

  // Called at a negedge; checks cost and the full pulse window.
  task automatic run_instr(int cls, int mode, bit pc, bit st, bit tk, bit pg);
    int exp;
    int bad;
    int first;
    exp = ref_cost(cls, mode, pc, st, tk, pg);
    drive(cls, mode, pc, st, tk, pg);
    @(negedge clk);
    start_i = 1'b0;
    check(int'(cost_o) == exp, tag_for(cls, mode, st), int'(cost_o), exp);
    bad = 0;
    first = -1;
    for (int j = 0; j < exp + 2; j++) begin
      if (done_o !== (j == exp - 1)) bad++;
      if (done_o === 1'b1 && first < 0) first = j;
      @(negedge clk);
    end
    check(bad == 0, "R9", first, exp - 1);
  endtask

  // Restart after d cycles of a running instruction A with instruction B.
  task automatic restart(int ca, int ma, int d, int cb, int mb, bit tk, bit pg);
    int expb;
    int bad;
    drive(ca, ma, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    bad = 0;
    for (int j = 0; j < d; j++) begin
      if (done_o !== 1'b0) bad++;
      @(negedge clk);
    end
    expb = ref_cost(cb, mb, 1'b0, 1'b0, tk, pg);
    drive(cb, mb, 1'b0, 1'b0, tk, pg);
    @(negedge clk);
    start_i = 1'b0;
    check(int'(cost_o) == expb, "R10", int'(cost_o), expb);
    for (int k = 0; k < expb + 3; k++) begin
      if (done_o !== (k == expb - 1)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int held;
    bit quiet;
    void'($urandom(32'h1cc5eed));
    repeat (3) @(negedge clk);
    check(cost_o == '0, "R1", int'(cost_o), 0);
    check(done_o == 1'b0, "R1", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cost_o == '0 && done_o == 1'b0, "R1", int'(cost_o), 0);

    // Exhaustive sweep: every class, mode code and flag combination.
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 16; m++)
        for (int f = 0; f < 16; f++)
          run_instr(c, m, f[3], f[2], f[1], f[0]);

    // Directed: the largest cost, then a quiet idle stretch.
    run_instr(1, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    held = int'(cost_o);
    quiet = 1'b1;
    for (int j = 0; j < 12; j++) begin
      if (done_o !== 1'b0) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R11", int'(done_o), 0);
    check(int'(cost_o) == held && held == 8, "R8", int'(cost_o), 8);

    // Directed restart: 6-cycle read abandoned after 2 cycles for a taken branch.
    restart(0, 7, 2, 2, 0, 1'b1, 1'b0);
    // Restart in the very cycle the pulse is showing.
    restart(1, 6, 6, 3, 5, 1'b0, 1'b0);

    // Random instructions and random restarts.
    repeat (300) begin
      run_instr(int'($urandom_range(3)), int'($urandom_range(15)),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    repeat (60) begin
      int ma;
      int ea;
      ma = int'($urandom_range(3, 8));
      ea = ref_cost(0, ma, 1'b0, 1'b0, 1'b0, 1'b0);
      restart(0, ma, int'($urandom_range(ea - 1)), int'($urandom_range(3)),
              int'($urandom_range(8)), 1'($urandom), 1'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule